// File: doc/BRIEF.md
# MDIO Management Master

This block is a hardware master for the two-wire Ethernet PHY management interface. A host presents one request at a time: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block builds the complete management frame and clocks it out on MDC. MDIO is driven through a separate output and output-enable pair, and the returned data is sampled from the MDIO input. When the frame ends, the block raises a one-clock done pulse. It then presents the read data and an error flag.

MDC is derived from the system clock. Each half period lasts `DIV` system clocks. The default of 10 keeps MDC at 2.5 MHz from a 50 MHz clock. The MDIO input passes through a two-flop synchroniser. The block samples it in the last system clock of each MDC high phase, so `DIV` must be at least 3.

On a read, the block checks the turnaround bit that the PHY should pull low. If the bit is high, no PHY answered. The block then runs a recovery burst of 32 released MDC cycles and ends the transaction with the error flag set.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `mdc` is low, `mdio_oe` is low, and `busy` and `done` are low. Straight after reset, `err` is 0 and `rdata` is 0.
- R2: While a transaction runs, every MDC high phase and every MDC low phase lasts exactly `DIV` system clocks.
- R3: Each frame begins with 32 MDC cycles in which MDIO is driven to 1.
- R4: MDC cycles 32 to 45 are always driven. They carry, in this order: the start bits 0 then 1; the opcode, which is 1,0 for a read and 0,1 for a write; the PHY address, most significant bit first; and the register address, most significant bit first.
- R5: `mdio_o` and `mdio_oe` change only while MDC is low. They stay constant for as long as MDC is high.
- R6: A write frame drives the turnaround as 1 then 0 in cycles 46 and 47. It drives the 16 data bits, MSB first, in cycles 48 to 63. Cycle 64 is a released cycle. The frame has 65 MDC cycles in total.
- R7: A read frame releases MDIO from cycle 46 onward. If the PHY drives the turnaround bit to 0 in cycle 46, the block captures data MSB first from cycles 47 to 62, then runs 2 more released cycles. It ends after 65 MDC cycles, with `err` at 0 and `rdata` holding the captured word.
- R8: If the turnaround bit sampled on a read is 1, the block runs 32 further released cycles, for 79 MDC cycles in total. It then ends with `err` at 1 and `rdata` at 0.
- R9: `done` is high for exactly one system clock, and `busy` falls in that same clock. `rdata` and `err` keep their values until the next request is accepted, and accepting a request clears both to 0. A request held during the `done` clock is accepted at the end of that clock.
- R10: A request presented while `busy` is high is ignored. The running frame is unchanged, and no extra frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock end-of-transaction pulse |
| err | output | 1 | The last read found no PHY |
| rdata | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Two events can fall in the same clock: the end of one transaction, with its done pulse and final read data, and the acceptance of the next request. The bench provokes this by raising the next read request during the done clock of a read. It then checks three things. In the done clock, `rdata` shows the first result. In the clock after, `done` is low, `busy` is high and `rdata` has been cleared. Finally, the second frame completes with its own word. A request pulsed in the middle of a write is judged the same way: the bench compares the whole recorded write frame against its own expected bits and cycle count.

// File: rtl/mdio_pkg.sv
// Package: constants and request type shared by the MDIO master modules.
// Assumes a single management bus and short (register-access) frames only.
package mdio_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    // preamble + start(2) + opcode(2) + two addresses
    localparam int HDR_BITS  = PRE_BITS + 4 + 2 * ADDR_W;
    // header + turnaround(2) + data
    localparam int FRAME_W   = HDR_BITS + 2 + DATA_W;
    localparam int FI_W      = $clog2(FRAME_W);
    localparam int RECOV     = 32;
    localparam int TA_SLOT   = HDR_BITS;
    localparam int RD_FIRST  = HDR_BITS + 1;
    localparam int RD_LAST   = HDR_BITS + DATA_W;
    localparam int LAST_OK   = FRAME_W;            // final released cycle
    localparam int LAST_BAD  = TA_SLOT + RECOV;    // end of recovery burst
    localparam int SLOT_W    = $clog2(LAST_BAD + 2);

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. While run is high, toggles mdc every DIV system
// clocks, starting from a full low phase. fall marks the system clock at the
// end of a high phase (the edge at which mdc returns low).
// Assumes DIV >= 1; mdc is forced low whenever run is low.
module mdio_clkgen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(DIV - 1));

    // half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign fall = run && mdc_q && wrap;

endmodule

// File: rtl/mdio_sync.sv
// Module: multi-flop synchroniser for the MDIO input pad.
// Assumes STAGES >= 2; resets to 1, the level of an idle pulled-up line.
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // shift the pad level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_seq.sv
// Module: frame sequencer. Latches a request, then on every MDC fall moves
// to the next MDC cycle ("slot") and sets the MDIO drive for it. It samples
// the synchronised input at the end of each high phase, checks the read
// turnaround, and reports done/err/rdata.
// Assumes fall is a one-clock strobe from mdio_clkgen and sdi is synchronised.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              fall,
    input  logic              sdi,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [SLOT_W-1:0]  slot_q, nxt_slot, last_slot;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  shreg_q, rdata_q;
    logic               busy_q, wr_q, ta_bad_q, done_q, err_q, o_q, oe_q;
    logic               nxt_o, nxt_oe;

    // drive for the next slot, and the slot that ends this transaction
    always_comb begin
        nxt_slot  = slot_q + 1'b1;
        nxt_o     = 1'b0;
        if (nxt_slot < SLOT_W'(FRAME_W))
            nxt_o = frame_q[~nxt_slot[FI_W-1:0]];
        nxt_oe    = wr_q ? (nxt_slot < SLOT_W'(FRAME_W))
                         : (nxt_slot < SLOT_W'(HDR_BITS));
        last_slot = ta_bad_q ? SLOT_W'(LAST_BAD) : SLOT_W'(LAST_OK);
    end

    // request capture, slot stepping, sampling and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            slot_q   <= '0;
            wr_q     <= 1'b0;
            frame_q  <= '0;
            shreg_q  <= '0;
            rdata_q  <= '0;
            ta_bad_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            o_q      <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q   <= 1'b1;
                slot_q   <= '0;
                wr_q     <= req.wr;
                frame_q  <= {{PRE_BITS{1'b1}}, 2'b01, req.wr ? OPC_WR : OPC_RD,
                             req.phy, req.regad, req.wr ? 2'b10 : 2'b11, req.wdata};
                shreg_q  <= '0;
                rdata_q  <= '0;
                err_q    <= 1'b0;
                ta_bad_q <= 1'b0;
                o_q      <= 1'b1;
                oe_q     <= 1'b1;
            end else if (busy_q && fall) begin
                if (!wr_q && slot_q == SLOT_W'(TA_SLOT))
                    ta_bad_q <= sdi;
                if (!wr_q && slot_q >= SLOT_W'(RD_FIRST) && slot_q <= SLOT_W'(RD_LAST))
                    shreg_q <= {shreg_q[DATA_W-2:0], sdi};
                if (slot_q == last_slot) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    err_q   <= ta_bad_q;
                    rdata_q <= (wr_q || ta_bad_q) ? '0 : shreg_q;
                    oe_q    <= 1'b0;
                end else begin
                    slot_q <= nxt_slot;
                    o_q    <= nxt_o;
                    oe_q   <= nxt_oe;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign err     = err_q;
    assign rdata   = rdata_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;

    // a new frame opens with a driven 1 (preamble)
    assert_preamble_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (oe_q && o_q));
    // a missing PHY never returns data
    assert_nophy_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && err_q) |-> (rdata_q == '0));
    // done lasts one clock only
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // busy can only end together with done
    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master top. Ties the MDC generator, the input
// synchroniser and the frame sequencer together.
// Assumes DIV >= 3, so that the synchronised input settles within a high phase.
module mdio_master #(
    parameter int DIV         = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    mdio_req_t req;
    logic      fall, sdi;

    assign req = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};

    mdio_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc), .fall(fall)
    );

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(sdi)
    );

    mdio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .req(req), .fall(fall),
        .sdi(sdi), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // bus quiet when idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
    // MDIO drive holds steady through every MDC high phase
    assert_mdio_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int DIV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        phy_oe = 1'b0, phy_o = 1'b1;
    logic        mdio_line;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master #(.DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // vectors: {write, phy, reg, data, phy_present}
    localparam logic [27:0] VEC [0:5] = '{
        {1'b1, 5'h01, 5'h00, 16'h1234, 1'b1},
        {1'b0, 5'h1F, 5'h1F, 16'hA5C3, 1'b1},
        {1'b1, 5'h10, 5'h11, 16'hFFFF, 1'b1},
        {1'b0, 5'h00, 5'h02, 16'h0001, 1'b1},
        {1'b0, 5'h15, 5'h0A, 16'h8000, 1'b1},
        {1'b0, 5'h07, 5'h03, 16'h0000, 1'b0}
    };

    // stimulus-side request, and its copy latched at frame start
    logic        cur_wr = 0, cur_pres = 1;
    logic [4:0]  cur_phy = 0, cur_reg = 0;
    logic [15:0] cur_data = 0;
    logic        l_wr = 0, l_pres = 1;
    logic [4:0]  l_phy = 0, l_reg = 0;
    logic [15:0] l_data = 0;
    logic        rec_o [0:79];
    logic        rec_oe[0:79];
    int          ecnt = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    logic        busy_p = 0, mdc_p = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural PHY, frame recorder, phase-length and contention monitor
    always @(negedge clk) begin
        if (busy && !busy_p) begin
            ecnt = 0; l_wr = cur_wr; l_pres = cur_pres; l_phy = cur_phy;
            l_reg = cur_reg; l_data = cur_data; phy_oe = 1'b0;
        end
        if (mdc && !mdc_p) begin
            if (ecnt < 80) begin rec_o[ecnt] = mdio_o; rec_oe[ecnt] = mdio_oe; end
            if (l_pres && !l_wr) begin
                if (ecnt == 46) begin phy_oe = 1'b1; phy_o = 1'b0; end
                else if (ecnt >= 47 && ecnt <= 62) phy_o = l_data[62 - ecnt];
                else if (ecnt == 63) phy_oe = 1'b0;
            end
            ecnt++;
            last_lo = lo_run; lo_run = 0;
        end
        if (mdc) hi_run++;
        else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
        if (busy && !mdc) lo_run++;
        if (!busy) lo_run = 0;
        if (mdio_oe && phy_oe) chk(0, "R7 bus contention", 1, 0);
        busy_p = busy; mdc_p = mdc;
    end

    // expected {oe, o} for MDC cycle s of the latched frame
    function automatic logic [1:0] exp_bit(input int s);
        if (s < 32)  return 2'b11;
        if (s == 32) return 2'b10;
        if (s == 33) return 2'b11;
        if (s == 34) return {1'b1, ~l_wr};
        if (s == 35) return {1'b1, l_wr};
        if (s <= 40) return {1'b1, l_phy[40 - s]};
        if (s <= 45) return {1'b1, l_reg[45 - s]};
        if (!l_wr)   return 2'b00;
        if (s == 46) return 2'b11;
        if (s == 47) return 2'b10;
        if (s <= 63) return {1'b1, l_data[63 - s]};
        return 2'b00;
    endfunction

    task automatic issue(input logic w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic pres);
        while (busy) @(negedge clk);
        cur_wr = w; cur_phy = p; cur_reg = r; cur_data = d; cur_pres = pres;
        req_write = w; req_phy = p; req_reg = r; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // wait for done, then judge the whole frame; returns in the done clock
    task automatic finish_check();
        int n, bad, first;
        string tag;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        tag = l_wr ? "R6" : (l_pres ? "R7" : "R8");
        chk(done, {tag, " done seen"}, done, 1);
        chk(ecnt == ((l_wr || l_pres) ? 65 : 79), {tag, " MDC cycle count"},
            ecnt, (l_wr || l_pres) ? 65 : 79);
        bad = 0; first = -1;
        for (int s = 0; s < 80; s++) begin
            if (s < ecnt) begin
                logic [1:0] e;
                e = exp_bit(s);
                if (rec_oe[s] !== e[1] || (e[1] && rec_o[s] !== e[0])) begin
                    bad++; if (first < 0) first = s;
                end
            end
        end
        chk(bad == 0, {tag, " R3 R4 frame bits, first bad cycle"}, first, -1);
        chk(err == (!l_wr && !l_pres), {tag, " err"}, err, !l_wr && !l_pres);
        chk(rdata == ((!l_wr && l_pres) ? l_data : 16'h0), {tag, " rdata"},
            rdata, (!l_wr && l_pres) ? l_data : 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mdc && !mdio_oe && !busy && !done, "R1 idle outputs",
            {mdc, mdio_oe, busy, done}, 0);
        chk(!err && rdata == 0, "R1 err/rdata reset", {err, rdata}, 0);
        repeat (20) @(negedge clk);
        chk(!mdc && !mdio_oe, "R1 quiet while idle", {mdc, mdio_oe}, 0);

        // table of vectors
        for (int i = 0; i < 6; i++) begin
            issue(VEC[i][27], VEC[i][26:22], VEC[i][21:17], VEC[i][16:1], VEC[i][0]);
            finish_check();
            @(negedge clk);
            chk(!done && !busy, "R9 done single clock", {done, busy}, 0);
            if (i == 0) begin
                chk(last_hi == DIV, "R2 high phase length", last_hi, DIV);
                chk(last_lo == DIV, "R2 low phase length", last_lo, DIV);
            end
        end

        // R9 hold after error read, then cleared on accept
        repeat (40) @(negedge clk);
        chk(err && rdata == 0, "R9 err held while idle", {err, rdata}, 17'h10000);
        issue(1'b0, 5'h02, 5'h05, 16'h5A5A, 1'b1);
        chk(!err && busy, "R9 err cleared on accept", {err, busy}, 1);
        finish_check();
        repeat (40) @(negedge clk);
        chk(rdata == 16'h5A5A && !err, "R9 rdata held while idle", rdata, 16'h5A5A);

        // R10 request during busy is ignored
        issue(1'b1, 5'h0C, 5'h13, 16'hC0DE, 1'b1);
        repeat (300) @(negedge clk);
        req_write = 1'b0; req_phy = 5'h1E; req_reg = 5'h01; req_wdata = 16'h0F0F;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        finish_check();
        repeat (60) @(negedge clk);
        chk(!busy, "R10 no extra frame after busy request", busy, 0);

        // R9 next request accepted in the done clock
        issue(1'b0, 5'h09, 5'h04, 16'h3C96, 1'b1);
        finish_check();
        chk(rdata == 16'h3C96, "R9 first result in done clock", rdata, 16'h3C96);
        cur_wr = 0; cur_phy = 5'h11; cur_reg = 5'h1B; cur_data = 16'hE71B; cur_pres = 1;
        req_write = 0; req_phy = 5'h11; req_reg = 5'h1B; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!done && busy && rdata == 0, "R9 accept in done clock",
            {done, busy, rdata}, 17'h10000);
        finish_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule